// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Four-Beat Line Refill

This block sits between an instruction fetch unit and a word-addressed backing memory. It holds a small number of four-word lines in a direct-mapped arrangement. A fetch that finds its line resident is answered from the on-chip data array. A fetch that misses starts a burst read of the whole line. The memory returns the four words one acknowledged beat at a time, with idle cycles between beats of any length. The cache stores each beat, marks the line valid after the fourth beat, and then answers the pending fetch.

Fetches can be chained. While a fetch is outstanding, the fetch unit holds a next strobe together with the following address. The cache takes that address at the same clock edge that raises the current acknowledge, so a run of hits is acknowledged on every cycle. A sync qualifier tells the cache whether a request line still held high in an acknowledge cycle is a fresh request or only the tail of the one just answered.

Top module: `fetch_line_cache`

## Requirements
- R1: Reset is synchronous and active high. After reset has been held for 4 cycles, `fe_ack` and `mem_req` are low, and every line is invalid, so the first fetch to any address misses.
- R2: A fetch presented while the cache is idle is answered by a one-cycle `fe_ack` in the second cycle after the cycle it was presented in, provided its line is resident, and no memory request is made. A fetch that misses is acknowledged no earlier than 5 cycles after it was presented.
- R3: A miss raises `mem_req` together with `mem_burst4`. `mem_addr` is the requested address with its two low bits cleared. The request stays high with a stable address until the cycle that carries the fourth `mem_ack`, and it is low in the cycle after that.
- R4: The cache takes `mem_data` only in cycles where `mem_ack` is high. It takes exactly four beats per refill, and beat k is stored as word line base + k, whatever the number of idle cycles before or between beats.
- R5: `fe_data`, valid while `fe_ack` is high, equals the memory word at the requested address on both the hit path and the miss path.
- R6: While a fetch is outstanding, the fetch unit may hold `fe_next` and `fe_req` high with the following address on `fe_addr`. That address is taken at the clock edge that raises the current `fe_ack`. The fetch unit then presents the address after it in the acknowledge cycle, and a run of hits is acknowledged on consecutive cycles.
- R7: When a chained fetch follows a refill, the following fetches to any word of the refilled line, in any order, hit. Their acknowledges follow the refill's acknowledge on consecutive cycles.
- R8: The line index is address bits [IW+1:2] (IW = log2 of the line count), and the tag is the remaining upper bits. Lines with different indices are resident together. A refill replaces only the line at its own index.
- R9: In a cycle where `fe_ack` is high and no chained address was taken, a high `fe_req` starts a new fetch only if `fe_sync` is also high. Otherwise it is ignored: no acknowledge and no memory request follow.
- R10: If `fe_req` drops while a refill is in progress, the refill still completes and the line becomes valid, but no `fe_ack` is issued for that fetch. `fe_ack` is never high while `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_req | input | 1 | Fetch request held high while a fetch is wanted |
| fe_addr | input | AW | Word address of the fetch, or of the chained fetch when fe_next is high |
| fe_next | input | 1 | The address on fe_addr is the following fetch, to be chained |
| fe_sync | input | 1 | fe_req in an acknowledge cycle is a fresh request |
| fe_ack | output | 1 | One-cycle acknowledge of a fetch |
| fe_data | output | DW | Instruction word, valid while fe_ack is high |
| mem_req | output | 1 | Refill request, held until the fourth beat |
| mem_addr | output | AW | Line-aligned refill address |
| mem_burst4 | output | 1 | Marks the refill as a four-beat burst |
| mem_ack | input | 1 | Memory beat strobe |
| mem_data | input | DW | Memory beat data, taken only when mem_ack is high |

## Verification
The memory model waits a different time before the first beat on each refill and leaves uneven gaps between beats. It drives a garbage word whenever its acknowledge is low. A cache that latched data without the strobe, miscounted beats, or used a line base that is not aligned would return wrong words. An address sweep over four times the cache capacity forces every index through replacement and checks each answer against the arithmetic memory content. It also measures latency, which exposes a hit served from a stale or evicted line as a wrong word or a missing refill. Chained runs in scrambled word order check that a hit run, or the run right after a refill, is acknowledged without a bubble. A design that read the data array before the refill's last write would stall or return the old line there. Targeted cases cover a stale request in an acknowledge cycle without the sync qualifier (a design ignoring it would start a spurious refill), an abandoned refill (a design that dropped it would refetch later, and one that answered it would raise a stray acknowledge), and reset clearing lines that were resident.

// File: rtl/fetch_line_cache_pkg.sv
package fetch_line_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOOK = 3'd1,
    ST_WAIT = 3'd2,
    ST_FILL = 3'd3,
    ST_RESP = 3'd4
  } fc_state_t;

  localparam int unsigned LINE_WORDS = 4;
  localparam int unsigned OFS_W      = 2;
endpackage

// File: rtl/fcache_data_ram.sv
module fcache_data_ram #(
  parameter int unsigned RAW = 4,
  parameter int unsigned DW  = 32
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << RAW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fcache_tag_store.sv
module fcache_tag_store #(
  parameter int unsigned LINES = 4,
  parameter int unsigned TW    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(LINES)-1:0] lk_idx,
  input  logic [TW-1:0]            lk_tag,
  output logic                     lk_hit,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [TW-1:0]            wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [TW-1:0]    tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/fetch_line_cache.sv
module fetch_line_cache #(
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 32,
  parameter int unsigned LINES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fe_req,
  input  logic [AW-1:0] fe_addr,
  input  logic          fe_next,
  input  logic          fe_sync,
  output logic          fe_ack,
  output logic [DW-1:0] fe_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_burst4,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_data
);
  import fetch_line_cache_pkg::*;

  localparam int unsigned IW  = $clog2(LINES);
  localparam int unsigned RAW = IW + OFS_W;
  localparam int unsigned TW  = AW - RAW;

  fc_state_t        state_q;
  logic [AW-1:0]    addr_q;
  logic [OFS_W-1:0] beat_q;
  logic [DW-1:0]    word_q;
  logic             drop_q;

  logic          hit;
  logic [DW-1:0] rd_word;
  logic          accept_idle;
  logic          gone;
  logic          resolve;
  logic          chain;
  logic          in_refill;
  logic          beat_we;
  logic          last_beat;

  logic [IW-1:0] look_idx;
  logic [TW-1:0] look_tag;

  assign look_idx = addr_q[OFS_W +: IW];
  assign look_tag = addr_q[AW-1 -: TW];

  assign accept_idle = (state_q == ST_IDLE) && fe_req && (!fe_ack || fe_sync);
  assign gone        = drop_q || !fe_req;
  assign resolve     = ((state_q == ST_LOOK) && hit) ||
                       ((state_q == ST_RESP) && !gone);
  assign chain       = resolve && fe_req && fe_next;
  assign in_refill   = (state_q == ST_WAIT) || (state_q == ST_FILL);
  assign beat_we     = in_refill && mem_ack;
  assign last_beat   = beat_we && (beat_q == OFS_W'(LINE_WORDS - 1));

  fcache_tag_store #(
    .LINES (LINES),
    .TW    (TW)
  ) u_tags (
    .clk    (clk),
    .rst    (rst),
    .lk_idx (look_idx),
    .lk_tag (look_tag),
    .lk_hit (hit),
    .wr_en  (last_beat),
    .wr_idx (look_idx),
    .wr_tag (look_tag)
  );

  fcache_data_ram #(
    .RAW (RAW),
    .DW  (DW)
  ) u_data (
    .clk   (clk),
    .we    (beat_we),
    .waddr ({look_idx, beat_q}),
    .wdata (mem_data),
    .raddr (fe_addr[RAW-1:0]),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      beat_q     <= '0;
      drop_q     <= 1'b0;
      fe_ack     <= 1'b0;
      mem_req    <= 1'b0;
      mem_burst4 <= 1'b0;
      mem_addr   <= '0;
    end else begin
      fe_ack <= resolve;
      if (accept_idle || chain) addr_q <= fe_addr;

      unique case (state_q)
        ST_IDLE: begin
          if (accept_idle) state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (hit) begin
            state_q <= chain ? ST_LOOK : ST_IDLE;
          end else begin
            state_q    <= ST_WAIT;
            mem_req    <= 1'b1;
            mem_burst4 <= 1'b1;
            mem_addr   <= {addr_q[AW-1:OFS_W], {OFS_W{1'b0}}};
            beat_q     <= '0;
            drop_q     <= 1'b0;
          end
        end
        ST_WAIT, ST_FILL: begin
          if (!fe_req) drop_q <= 1'b1;
          if (beat_we) begin
            beat_q  <= beat_q + 1'b1;
            state_q <= ST_FILL;
          end
          if (last_beat) begin
            state_q    <= ST_RESP;
            mem_req    <= 1'b0;
            mem_burst4 <= 1'b0;
          end
        end
        ST_RESP: begin
          state_q <= chain ? ST_LOOK : ST_IDLE;
          drop_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (beat_we && (beat_q == addr_q[OFS_W-1:0])) word_q <= mem_data;
    if (resolve) fe_data <= (state_q == ST_LOOK) ? rd_word : word_q;
  end
endmodule

// File: rtl/fetch_line_cache_chk.sv
module fetch_line_cache_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          fe_ack,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_burst4,
  input logic          mem_ack
);
  logic [2:0] beats_seen;

  always_ff @(posedge clk) begin
    if (rst || !mem_req) beats_seen <= '0;
    else if (mem_ack)    beats_seen <= beats_seen + 3'd1;
  end

  // R3
  burst_flag_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_burst4);

  // R3
  line_base_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R4
  beat_total_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_req) |-> (beats_seen == 3'd4));

  // R4
  beat_limit_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (beats_seen < 3'd4));

  // R10
  quiet_fill_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !fe_ack);
endmodule

bind fetch_line_cache fetch_line_cache_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fe_ack     (fe_ack),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_burst4 (mem_burst4),
  .mem_ack    (mem_ack)
);

// File: tb/tb_fetch_line_cache.sv
module tb_fetch_line_cache;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int LINES = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fe_req = 1'b0;
  logic [AW-1:0] fe_addr = '0;
  logic          fe_next = 1'b0;
  logic          fe_sync = 1'b0;
  logic          fe_ack;
  logic [DW-1:0] fe_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_burst4;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_data = '0;

  int  checks = 0;
  int  errors = 0;
  int  reqs   = 0;
  int  acks   = 0;
  bit  done   = 1'b0;
  int  res_line [LINES];
  bit  res_ok   [LINES];

  always #5 clk = ~clk;

  fetch_line_cache #(.AW(AW), .DW(DW), .LINES(LINES)) dut (
    .clk(clk), .rst(rst), .fe_req(fe_req), .fe_addr(fe_addr),
    .fe_next(fe_next), .fe_sync(fe_sync), .fe_ack(fe_ack), .fe_data(fe_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_burst4(mem_burst4),
    .mem_ack(mem_ack), .mem_data(mem_data)
  );

  function automatic logic [DW-1:0] word_of(input int a);
    return (32'(a) * 32'h0001_0003) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit model_hit(input int a);
    int ln = a / 4;
    return res_ok[ln % LINES] && (res_line[ln % LINES] == ln);
  endfunction

  function automatic void model_fill(input int a);
    res_ok[(a / 4) % LINES]   = 1'b1;
    res_line[(a / 4) % LINES] = a / 4;
  endfunction

  // memory model: variable first-beat delay, uneven gaps, garbage when idle
  int gseq = 0;
  initial begin
    int beat = 0;
    int wcnt = -1;
    forever begin
      @(negedge clk);
      mem_ack  = 1'b0;
      mem_data = 32'hDEAD_BEEF;
      if (!mem_req) begin
        beat = 0;
        wcnt = -1;
      end else begin
        if (wcnt < 0) wcnt = 1 + (gseq % 4);
        if (wcnt > 0) wcnt--;
        else begin
          mem_ack  = 1'b1;
          mem_data = word_of(int'(mem_addr) + beat);
          beat++;
          gseq++;
          wcnt = gseq % 3;
        end
      end
    end
  end

  // request monitor
  initial begin
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (fe_ack) acks++;
      if (mem_req && !prev) begin
        reqs++;
        // R3 line-aligned burst request
        chk(mem_burst4 && (mem_addr[1:0] == 2'b00), "R3 burst/base", {mem_burst4, mem_addr}, 0);
      end
      prev = mem_req;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    fe_req = 1'b0; fe_next = 1'b0; fe_sync = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < LINES; i++) res_ok[i] = 1'b0;
  endtask

  task automatic fetch_single(input int a);
    bit exp_hit = model_hit(a);
    int r0 = reqs;
    int lat = 0;
    fe_req = 1'b1; fe_sync = 1'b1; fe_next = 1'b0; fe_addr = AW'(a);
    do begin
      @(negedge clk);
      lat++;
    end while (!fe_ack && lat < 200);
    fe_req = 1'b0; fe_sync = 1'b0;
    // R5 returned word
    chk(fe_data == word_of(a), "R5 data", fe_data, word_of(a));
    if (exp_hit) begin
      // R2 hit latency and no refill
      chk(lat == 2, "R2 hit latency", lat, 2);
      chk(reqs == r0, "R2 no refill on hit", reqs - r0, 0);
    end else begin
      // R2 miss latency
      chk(lat > 4 && lat < 200, "R2 miss latency", lat, 5);
      chk(reqs == r0 + 1, "R8 one refill on miss", reqs - r0, 1);
      model_fill(a);
    end
  endtask

  // mode 0: no gap check; 1: every ack consecutive; 2: consecutive after first ack
  task automatic run_seq(input int seq[], input int mode, input string tag);
    int n = seq.size();
    int sent = 0;
    int got = 0;
    int misses = 0;
    int r0 = reqs;
    int cyc = 0;
    int last_ack = 0;
    for (int i = 0; i < n; i++) begin
      if (!model_hit(seq[i])) begin misses++; model_fill(seq[i]); end
    end
    fe_req = 1'b1; fe_sync = 1'b1; fe_next = 1'b0; fe_addr = AW'(seq[0]);
    @(negedge clk);
    cyc++;
    if (n > 1) begin sent = 1; fe_next = 1'b1; fe_addr = AW'(seq[1]); end
    while (got < n && cyc < 2000) begin
      if (fe_ack) begin
        chk(fe_data == word_of(seq[got]), {tag, " data"}, fe_data, word_of(seq[got]));
        if (got > 0 && (mode == 1 || (mode == 2)))
          chk(cyc - last_ack == 1, {tag, " back-to-back"}, cyc - last_ack, 1);
        last_ack = cyc;
        got++;
        if (got == n) begin
          fe_req = 1'b0; fe_next = 1'b0;
        end else if (sent < n - 1) begin
          sent++;
          fe_addr = AW'(seq[sent]);
        end else begin
          fe_next = 1'b0;
        end
      end
      if (got < n) begin
        @(negedge clk);
        cyc++;
      end
    end
    fe_sync = 1'b0;
    chk(got == n, {tag, " ack count"}, got, n);
    chk(reqs - r0 == misses, "R8 refills in run", reqs - r0, misses);
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin res_ok[i] = 1'b0; res_line[i] = 0; end
    do_reset();
    // R1 reset state
    chk(fe_ack == 1'b0, "R1 ack after reset", fe_ack, 0);
    chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);

    // R2 R5 R8 sweep over four times capacity; only line bases miss
    for (int a = 0; a < 64; a++) fetch_single(a);

    // R6 all-hit chained run in scrambled order
    run_seq('{49, 51, 48, 50, 50, 63, 60, 56, 52, 61}, 1, "R6");
    // R7 refill then chained hits to the same line
    run_seq('{100, 102, 101, 103, 100, 102}, 2, "R7");
    // R4 R5 chained run with misses in the middle
    run_seq('{4, 8, 9, 5, 6, 10, 11, 7}, 0, "R4");

    // R8 two indices resident together, then a conflict on one index
    fetch_single(7);
    fetch_single(11);
    fetch_single(20);
    fetch_single(5);
    fetch_single(10);

    // R9 stale request in an acknowledge cycle without sync is ignored
    begin
      int r0;
      int a0;
      fetch_single(9);
      fe_req = 1'b1; fe_sync = 1'b0; fe_next = 1'b0; fe_addr = AW'(9);
      do @(negedge clk); while (!fe_ack);
      fe_addr = AW'(200);
      r0 = reqs; a0 = acks;
      @(negedge clk);
      fe_req = 1'b0;
      repeat (12) @(negedge clk);
      chk(reqs == r0, "R9 no refill without sync", reqs - r0, 0);
      chk(acks == a0, "R9 no ack without sync", acks - a0, 0);
      // with sync the same timing starts a fetch
      fe_req = 1'b1; fe_sync = 1'b1; fe_addr = AW'(9);
      do @(negedge clk); while (!fe_ack);
      fe_addr = AW'(201);
      r0 = reqs;
      begin
        int lat = 0;
        do begin @(negedge clk); lat++; end while (!fe_ack && lat < 200);
        fe_req = 1'b0; fe_sync = 1'b0;
        chk(fe_data == word_of(201), "R9 synced fetch data", fe_data, word_of(201));
        chk(reqs == r0 + 1, "R9 synced fetch refill", reqs - r0, 1);
      end
      model_fill(201);
    end

    // R10 abandoned refill completes silently
    begin
      int a0;
      @(negedge clk);
      fe_req = 1'b1; fe_sync = 1'b1; fe_addr = AW'(330);
      do @(negedge clk); while (!mem_req);
      fe_req = 1'b0; fe_sync = 1'b0;
      a0 = acks;
      repeat (30) @(negedge clk);
      chk(acks == a0, "R10 no ack for dropped fetch", acks - a0, 0);
      chk(mem_req == 1'b0, "R10 refill finished", mem_req, 0);
      model_fill(330);
      fetch_single(331);
      fetch_single(328);
    end

    // R1 reset clears resident lines
    fetch_single(40);
    do_reset();
    chk(fe_ack == 1'b0 && mem_req == 1'b0, "R1 outputs after second reset", {fe_ack, mem_req}, 0);
    fetch_single(41);
    fetch_single(331);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule